// File: doc/BRIEF.md
# Operand Loader and Result Multiplexer

This block is the pin-side front end of a narrow-bus arithmetic unit. An 8-bit shared data bus and a single address bit fill two operand registers, X and Y, one register per clock. The block hands both operands and two mode bits to an attached multiply/divide core, then returns that core's 16-bit answer through one 8-bit output port. The same address bit that picks the operand register to load also picks which half of the answer appears on the output.

A run-time control picks how the answer is shown. In the immediate view the output follows the core combinationally. In the registered view the full answer and its error flags are captured on the rising edge. That captured copy lets a new request be loaded while the previous answer is still being read. Operands are loaded on the falling edge, so a request loaded in one half-cycle is captured at the next rising edge. The arithmetic core here is a behavioural stand-in.

Top module: `opmux_frontend`

## Requirements
- R1: On each falling clock edge with reset inactive, the data bus is written into X when the address bit is 0 or into Y when it is 1, and the other operand keeps its value.
- R2: Operands change only at the falling edge: between a rising edge and the following falling edge, the immediate output reflects the operands loaded before that rising edge.
- R3: With the mode bit at 0 (multiply) the answer is X*Y as a 16-bit product, read as unsigned when the signed bit is 0 and as two's complement when it is 1, and both error outputs are 0.
- R4: With the mode bit at 1 (divide) the answer's low byte is the quotient X/Y truncated toward zero and its high byte is the remainder, which takes the sign of X in signed mode.
- R5: A divide with Y equal to 0 raises the divide-by-zero output, leaves overflow at 0, and gives quotient 0xFF and remainder X.
- R6: A signed divide of 0x80 by 0xFF raises the overflow output and gives quotient 0x80 and remainder 0.
- R7: The output carries bits 7:0 of the selected answer when the address bit is 0 and bits 15:8 when it is 1.
- R8: With the view control at 0, the output and error pins follow the core's current answer with no rising edge needed.
- R9: With the view control at 1, the answer is captured at each rising edge and shown from the capture register; while the control is 0 the capture register holds its value.
- R10: In the registered view the error outputs come from the captured flags, not from the core's current flags.
- R11: With the active-low reset held low, both operands clear at the falling edge and the capture register clears at the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands load on the fall, capture on the rise |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Shared operand bus |
| addr | input | 1 | Selects operand register to load and answer half to show |
| reg_view | input | 1 | 0 shows the core directly, 1 shows the capture register |
| op_div | input | 1 | 0 multiply, 1 divide |
| op_signed | input | 1 | 0 unsigned, 1 two's complement |
| result_out | output | 8 | Selected half of the answer |
| err_div0 | output | 1 | Divide-by-zero flag |
| err_ovf | output | 1 | Divide overflow flag |

## Verification
An operand register holding the wrong value shows in the immediate view in the same half-cycle after the falling edge that loads it. A capture register that updates or holds at the wrong time shows on the output within one rising edge once the view control is 1. Because reading the other half of the answer also writes a register, a wrong address decode corrupts the next answer that is read. The bench compares every output in two windows of every cycle, before and after the falling edge, so a load on the wrong edge is caught in the first cycle it happens.

// File: rtl/opmux_pkg.sv
package opmux_pkg;

    typedef struct packed {
        logic div0;
        logic ovf;
    } err_t;

    localparam int ERR_BITS = 2;

endpackage

// File: rtl/opmux_operands.sv
module opmux_operands #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         addr,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] opnd_x,
    output logic [W-1:0] opnd_y
);
    localparam int NREG = 2;

    logic [W-1:0] bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                bank[i] <= '0;
            end else if (addr == i[0]) begin
                bank[i] <= data_in;
            end
        end
    end

    assign opnd_x = bank[0];
    assign opnd_y = bank[1];

endmodule

// File: rtl/opmux_arith_stub.sv
module opmux_arith_stub
    import opmux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   opnd_x,
    input  logic [W-1:0]   opnd_y,
    input  logic           op_div,
    input  logic           op_signed,
    output logic [2*W-1:0] core_res,
    output err_t           core_err
);
    localparam int RW = 2 * W;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [RW-1:0] ext_x, ext_y, prod;
    logic          neg_x, neg_y;
    logic [W-1:0]  mag_x, mag_y, uq, ur, quo, rem;

    always_comb begin
        ext_x = {{W{opnd_x[W-1] & op_signed}}, opnd_x};
        ext_y = {{W{opnd_y[W-1] & op_signed}}, opnd_y};
        prod  = ext_x * ext_y;

        neg_x = op_signed & opnd_x[W-1];
        neg_y = op_signed & opnd_y[W-1];
        mag_x = neg_x ? (~opnd_x + 1'b1) : opnd_x;
        mag_y = neg_y ? (~opnd_y + 1'b1) : opnd_y;
        uq    = (mag_y == '0) ? '0 : (mag_x / mag_y);
        ur    = (mag_y == '0) ? '0 : (mag_x % mag_y);
        quo   = (neg_x ^ neg_y) ? (~uq + 1'b1) : uq;
        rem   = neg_x ? (~ur + 1'b1) : ur;

        core_err = '0;
        if (!op_div) begin
            core_res = prod;
        end else if (opnd_y == '0) begin
            core_err.div0 = 1'b1;
            core_res      = {opnd_x, {W{1'b1}}};
        end else begin
            core_err.ovf = op_signed && (opnd_x == MIN_NEG) && (opnd_y == '1);
            core_res     = {rem, quo};
        end
    end

endmodule

// File: rtl/opmux_result_stage.sv
module opmux_result_stage
    import opmux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_view,
    input  logic                      addr,
    input  logic [2*W-1:0]            core_res,
    input  err_t                      core_err,
    output logic [2*W+ERR_BITS-1:0]   res_q,
    output logic [W-1:0]              result_out,
    output err_t                      err_out
);
    localparam int RW = 2 * W;
    localparam int CW = RW + ERR_BITS;

    logic [CW-1:0] live_word, view_word;

    assign live_word = {core_err, core_res};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (reg_view) begin
            res_q <= live_word;
        end
    end

    always_comb begin
        view_word  = reg_view ? res_q : live_word;
        result_out = addr ? view_word[RW-1:W] : view_word[W-1:0];
        err_out    = err_t'(view_word[CW-1:RW]);
    end

endmodule

// File: rtl/opmux_frontend.sv
module opmux_frontend
    import opmux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_in,
    input  logic         addr,
    input  logic         reg_view,
    input  logic         op_div,
    input  logic         op_signed,
    output logic [W-1:0] result_out,
    output logic         err_div0,
    output logic         err_ovf
);
    localparam int RW = 2 * W;
    localparam int CW = RW + ERR_BITS;

    logic [W-1:0]  opnd_x, opnd_y;
    logic [RW-1:0] core_res;
    err_t          core_err, err_out;
    logic [CW-1:0] res_q;

    opmux_operands #(.W(W)) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .data_in (data_in),
        .opnd_x  (opnd_x),
        .opnd_y  (opnd_y)
    );

    opmux_arith_stub #(.W(W)) u_core (
        .opnd_x    (opnd_x),
        .opnd_y    (opnd_y),
        .op_div    (op_div),
        .op_signed (op_signed),
        .core_res  (core_res),
        .core_err  (core_err)
    );

    opmux_result_stage #(.W(W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_view   (reg_view),
        .addr       (addr),
        .core_res   (core_res),
        .core_err   (core_err),
        .res_q      (res_q),
        .result_out (result_out),
        .err_out    (err_out)
    );

    assign err_div0 = err_out.div0;
    assign err_ovf  = err_out.ovf;

endmodule

// File: rtl/opmux_frontend_chk.sv
module opmux_frontend_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           addr,
    input logic [W-1:0]   data_in,
    input logic           reg_view,
    input logic           op_div,
    input logic           err_div0,
    input logic           err_ovf,
    input logic [W-1:0]   opnd_x,
    input logic [W-1:0]   opnd_y,
    input logic [2*W-1:0] core_res,
    input logic [1:0]     core_err,
    input logic [2*W+1:0] res_q
);
    AST_X_LOAD: assert property (@(negedge clk) disable iff (!rst_n)
        !addr |=> opnd_x == $past(data_in)); // R1
    AST_Y_KEEP: assert property (@(negedge clk) disable iff (!rst_n)
        !addr |=> $stable(opnd_y)); // R1
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_view |=> res_q == $past({core_err, core_res})); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_view |=> $stable(res_q)); // R9
    AST_MUL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_div && !reg_view) |-> (!err_div0 && !err_ovf)); // R3
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_div0 && err_ovf)); // R5
endmodule

bind opmux_frontend opmux_frontend_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .data_in  (data_in),
    .reg_view (reg_view),
    .op_div   (op_div),
    .err_div0 (err_div0),
    .err_ovf  (err_ovf),
    .opnd_x   (opnd_x),
    .opnd_y   (opnd_y),
    .core_res (core_res),
    .core_err (core_err),
    .res_q    (res_q)
);

// File: tb/sim_opmux_frontend.sv
`timescale 1ns/1ps
module sim_opmux_frontend;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = '0;
    logic       addr = 1'b0;
    logic       reg_view = 1'b0;
    logic       op_div = 1'b0;
    logic       op_signed = 1'b0;
    logic [7:0] result_out;
    logic       err_div0, err_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          x_m = 0, y_m = 0;
    logic [17:0] cap_m = '0;

    always #4 clk = ~clk;

    opmux_frontend u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .addr(addr),
        .reg_view(reg_view), .op_div(op_div), .op_signed(op_signed),
        .result_out(result_out), .err_div0(err_div0), .err_ovf(err_ovf)
    );

    function automatic logic [17:0] ref_word(int xv, int yv, bit dv, bit sg);
        int a, b, p, q, r;
        logic [15:0] res;
        bit d0 = 0, ov = 0;
        a = (sg && xv > 127) ? xv - 256 : xv;
        b = (sg && yv > 127) ? yv - 256 : yv;
        if (!dv) begin
            p = a * b; res = p[15:0];
        end else if (yv == 0) begin
            d0 = 1; res = {xv[7:0], 8'hFF};
        end else if (sg && xv == 128 && yv == 255) begin
            ov = 1; res = 16'h0080;
        end else begin
            q = a / b; r = a % b; res = {r[7:0], q[7:0]};
        end
        return {d0, ov, res};
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin x_m <= 0; y_m <= 0; end
        else if (addr) y_m <= int'(data_in);
        else x_m <= int'(data_in);
    end

    always @(posedge clk) begin
        if (!rst_n) cap_m <= '0;
        else if (reg_view) cap_m <= ref_word(x_m, y_m, op_div, op_signed);
    end

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic model_cmp(input string tag);
        logic [17:0] w;
        logic [7:0] half;
        w = reg_view ? cap_m : ref_word(x_m, y_m, op_div, op_signed);
        half = addr ? w[15:8] : w[7:0];
        chk(tag, {err_div0, err_ovf, result_out}, {w[17], w[16], half});
    endtask

    task automatic step(input logic [7:0] d, input logic a, input logic rv,
                        input logic dv, input logic sg);
        @(posedge clk);
        #1;
        data_in = d; addr = a; reg_view = rv; op_div = dv; op_signed = sg;
        #1;
        if (rst_n) model_cmp("R2 pre-fall");
        #4;
        if (rst_n) model_cmp(rv ? "R9 model" : "R8 model");
    endtask

    task automatic expect_pins(input string tag, input logic [7:0] r,
                               input logic d0, input logic ov);
        chk(tag, {err_div0, err_ovf, result_out}, {d0, ov, r});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset clears operands and capture register
        step(8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
        step(8'h66, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_pins("R11 reset hi", 8'h00, 1'b0, 1'b0);
        step(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_pins("R11 reset lo", 8'h00, 1'b0, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 R3 R7: unsigned multiply 200*3 = 0x0258
        step(8'd200, 1'b0, 1'b0, 1'b0, 1'b0);
        step(8'd3,   1'b1, 1'b0, 1'b0, 1'b0);
        expect_pins("R7 R3 mul hi", 8'h02, 1'b0, 1'b0);
        step(8'd200, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_pins("R1 R7 mul lo", 8'h58, 1'b0, 1'b0);
        // R3 signed: -56*3 = 0xFF58
        step(8'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_pins("R3 smul hi", 8'hFF, 1'b0, 1'b0);

        // R4 unsigned divide 100/7 -> q 14 r 2
        step(8'd100, 1'b0, 1'b0, 1'b1, 1'b0);
        step(8'd7,   1'b1, 1'b0, 1'b1, 1'b0);
        expect_pins("R4 udiv rem", 8'h02, 1'b0, 1'b0);
        step(8'd100, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_pins("R4 udiv quo", 8'h0E, 1'b0, 1'b0);
        // R4 signed -100/7 -> q 0xF2 r 0xFE
        step(8'h9C, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_pins("R4 sdiv quo", 8'hF2, 1'b0, 1'b0);
        step(8'd7, 1'b1, 1'b0, 1'b1, 1'b1);
        expect_pins("R4 sdiv rem", 8'hFE, 1'b0, 1'b0);

        // R5 divide by zero
        step(8'd9, 1'b0, 1'b0, 1'b1, 1'b0);
        step(8'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_pins("R5 div0 rem", 8'h09, 1'b1, 1'b0);
        step(8'd9, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_pins("R5 div0 quo", 8'hFF, 1'b1, 1'b0);

        // R6 signed overflow
        step(8'h80, 1'b0, 1'b0, 1'b1, 1'b1);
        step(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1);
        expect_pins("R6 ovf rem", 8'h00, 1'b0, 1'b1);
        step(8'h80, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_pins("R6 ovf quo", 8'h80, 1'b0, 1'b1);
        // R3 errors muted in multiply
        step(8'h80, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_pins("R3 mul no err", 8'h80, 1'b0, 1'b0);

        // R9 registered view: 100*20 = 0x07D0
        step(8'd100, 1'b0, 1'b1, 1'b0, 1'b0);
        step(8'd20,  1'b1, 1'b1, 1'b0, 1'b0);
        step(8'd20,  1'b1, 1'b1, 1'b0, 1'b0);
        expect_pins("R9 cap hi", 8'h07, 1'b0, 1'b0);
        step(8'd100, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_pins("R9 cap lo", 8'hD0, 1'b0, 1'b0);
        step(8'd5, 1'b0, 1'b0, 1'b0, 1'b0);
        step(8'd5, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_pins("R8 live", 8'h00, 1'b0, 1'b0);
        step(8'd5, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_pins("R9 held", 8'h07, 1'b0, 1'b0);
        step(8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_pins("R9 new cap", 8'h19, 1'b0, 1'b0);

        // R10 captured error flags
        step(8'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        step(8'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        step(8'd3, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_pins("R10 err held", 8'h05, 1'b1, 1'b0);
        step(8'd3, 1'b1, 1'b1, 1'b1, 1'b0);
        expect_pins("R10 err cleared", 8'h02, 1'b0, 1'b0);

        // mixed random traffic, compared against the model every cycle
        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            d = (i % 17 == 0) ? 8'h00 : ((i % 23 == 0) ? 8'hFF : 8'($urandom));
            step(d, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule